// File: doc/BRIEF.md
# Sleep Wake Power Controller

This controller sits beside a processor core that has a sleep mode. When the core raises its sleep request and no wake condition is pending, the controller turns off the core clock-enable. The clock comes back as soon as a qualified wake condition appears. A wake condition is one of three things: a noncritical external interrupt while the core's external-interrupt enable is set, a critical external interrupt while the core's critical-interrupt enable is set, or a timer interrupt request from the core.

On wake-up the core drops its two enable lines and its timer request one clock before it drops the sleep request. For this reason the controller registers those three status lines on every clock and makes all of its decisions from the registered copies. The raw interrupt lines are used directly.

The controller has three states: RUN, SLEEP and WAKE. It stays in WAKE until the core withdraws its sleep request, so it cannot fall back asleep on the same request that it just woke from. A cause vector records which source ended the sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, ctrl_state is RUN (encoding 0), core_clk_en is 1 and wake_cause is 0.
- R2: In RUN, with core_sleep_req high and no wake condition, the next clock edge moves ctrl_state to SLEEP (encoding 1) and drives core_clk_en to 0.
- R3: In RUN, a pending wake condition keeps the controller in RUN even while core_sleep_req is high.
- R4: In SLEEP, ext_irq wakes the controller (next edge: WAKE, encoding 2, core_clk_en 1) only when the registered external-interrupt enable is 1.
- R5: In SLEEP, crit_irq wakes the controller only when the registered critical-interrupt enable is 1.
- R6: In SLEEP, a registered core_timer_irq wakes the controller. A timer request that arrives in SLEEP wakes it on the second edge.
- R7: WAKE is held while core_sleep_req stays high, even after the enables and the timer request drop. The first edge with core_sleep_req low returns the controller to RUN.
- R8: On the SLEEP-to-WAKE edge, wake_cause captures bit0 = noncritical wake, bit1 = critical wake and bit2 = timer wake. It holds that value through WAKE and is cleared to 0 in RUN.
- R9: The enable and timer inputs act one edge after they change. An enable that drops on the same edge as its interrupt still wakes the controller. An enable that rises on the same edge as its interrupt does not wake it until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_sleep_req | input | 1 | Sleep request from the core |
| core_ext_irq_en | input | 1 | Core's noncritical-interrupt enable state |
| core_crit_irq_en | input | 1 | Core's critical-interrupt enable state |
| core_timer_irq | input | 1 | Timer interrupt request from the core |
| ext_irq | input | 1 | External noncritical interrupt line |
| crit_irq | input | 1 | External critical interrupt line |
| core_clk_en | output | 1 | Core clock enable, 0 while asleep |
| ctrl_state | output | 2 | 0 RUN, 1 SLEEP, 2 WAKE |
| wake_cause | output | 3 | Wake source latched on wake-up |

## Verification
Each state change is due one edge after its stimulus. Wakes that come from interrupts appear one edge after the interrupt. A wake from a timer request that arrives in SLEEP appears after two edges, because the request is registered first. The bench drives inputs on the falling edge and samples one falling edge after each rising edge, so every expected value lines up with that latency. All 32 combinations of enables, timer and interrupts are swept, and expected state and cause are computed arithmetically from those bits.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_sleep_req,
  input  logic       core_ext_irq_en,
  input  logic       core_crit_irq_en,
  input  logic       core_timer_irq,
  input  logic       ext_irq,
  input  logic       crit_irq,
  output logic       core_clk_en,
  output logic [1:0] ctrl_state,
  output logic [2:0] wake_cause
);
  localparam logic [1:0] ST_RUN = 2'd0, ST_SLEEP = 2'd1, ST_WAKE = 2'd2;

  logic [1:0] state;
  logic       ext_en_q, crit_en_q, tmr_q;
  logic [2:0] cause_now;
  logic       wake_any;

  // status lines from the core fall one cycle early: use registered copies only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_en_q  <= 1'b0;
      crit_en_q <= 1'b0;
      tmr_q     <= 1'b0;
    end else begin
      ext_en_q  <= core_ext_irq_en;
      crit_en_q <= core_crit_irq_en;
      tmr_q     <= core_timer_irq;
    end
  end

  assign cause_now = {tmr_q, crit_irq & crit_en_q, ext_irq & ext_en_q};
  assign wake_any  = |cause_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      wake_cause <= 3'b000;
    end else begin
      case (state)
        ST_RUN:   if (core_sleep_req && !wake_any) state <= ST_SLEEP;
        ST_SLEEP: if (wake_any) begin
                    state      <= ST_WAKE;
                    wake_cause <= cause_now;
                  end
        ST_WAKE:  if (!core_sleep_req) begin
                    state      <= ST_RUN;
                    wake_cause <= 3'b000;
                  end
        default:  state <= ST_RUN;
      endcase
    end
  end

  assign core_clk_en = (state != ST_SLEEP);
  assign ctrl_state  = state;

  AST_RESET_RUN: assert property (@(posedge clk) !rst_n |=> (state == ST_RUN && wake_cause == 3'b000)); // R1
  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && core_sleep_req && !wake_any) |=> !core_clk_en); // R2
  AST_NO_SLEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && wake_any) |=> state == ST_RUN); // R3
  AST_WAKE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && wake_any) |=> core_clk_en); // R4
  AST_TIMER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && tmr_q) |=> (state == ST_WAKE && wake_cause[2])); // R6
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && core_sleep_req) |=> (state == ST_WAKE && $stable(wake_cause))); // R7
  AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> wake_cause == 3'b000); // R8
  AST_NO_RUN_TO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> state != ST_WAKE); // R7
endmodule

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sreq = 0, een = 0, cen = 0, tmr = 0, eirq = 0, cirq = 0;
  logic clk_en;
  logic [1:0] st;
  logic [2:0] cause;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .core_sleep_req(sreq),
    .core_ext_irq_en(een), .core_crit_irq_en(cen), .core_timer_irq(tmr),
    .ext_irq(eirq), .crit_irq(cirq),
    .core_clk_en(clk_en), .ctrl_state(st), .wake_cause(cause)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; sreq = 0; een = 0; cen = 0; tmr = 0; eirq = 0; cirq = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 state", st, 0); chk("R1 clk_en", clk_en, 1); chk("R1 cause", cause, 0);

    for (int v = 0; v < 32; v++) begin
      bit ee, ce, t, ei, ci, iw;
      int exp_cause;
      ee = v[0]; ce = v[1]; t = v[2]; ei = v[3]; ci = v[4];
      do_reset();
      een = ee; cen = ce;
      tick();
      sreq = 1;
      tick();
      chk("R2 state", st, 1); chk("R2 clk_en", clk_en, 0);
      tmr = t; eirq = ei; cirq = ci;
      tick();
      iw = (ei & ee) | (ci & ce);
      exp_cause = iw ? ((ci & ce) << 1) | (ei & ee) : 0;
      chk(ei & ee ? "R4 first edge" : "R5 first edge", st, iw ? 2 : 1);
      chk("R8 cause first edge", cause, exp_cause);
      tick();
      if (!iw && t) exp_cause = 4;
      chk("R6 second edge", st, (iw || t) ? 2 : 1);
      chk("R6 clk_en", clk_en, (iw || t) ? 1 : 0);
      chk("R8 cause held", cause, exp_cause);
      if (iw || t) begin
        een = 0; cen = 0; tmr = 0; eirq = 0; cirq = 0;
        tick();
        chk("R7 hold", st, 2);
        chk("R7 cause held", cause, exp_cause);
        sreq = 0;
        tick();
        chk("R7 back to RUN", st, 0);
        chk("R8 cause cleared", cause, 0);
      end
    end

    do_reset();
    tmr = 1;
    tick();
    sreq = 1;
    tick();
    chk("R3 stay RUN", st, 0); chk("R3 clk_en", clk_en, 1);

    do_reset();
    een = 1; tick();
    sreq = 1; tick();
    chk("R2 sleep", st, 1);
    een = 0; eirq = 1;
    tick();
    chk("R9 late-drop enable wakes", st, 2);
    chk("R9 cause", cause, 1);

    do_reset();
    sreq = 1; tick();
    chk("R2 sleep", st, 1);
    cen = 1; cirq = 1;
    tick();
    chk("R9 new enable not yet", st, 1);
    tick();
    chk("R9 enable now active", st, 2);
    chk("R5 cause", cause, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule